// File: doc/BRIEF.md
# Cascadable Magnitude Comparator

This block compares two unsigned words and reports, on three mutually exclusive flags, whether the first word is greater than, equal to or less than the second. It is built from identical 4-bit slices. Each slice works out the order of its own two nibbles. When the nibbles are equal, the slice passes on the verdict it receives from the next less significant slice.

The top wrapper chains `SLICES` slices, so the compared width is four bits per slice. The least significant slice is seeded with a fixed "equal" verdict. The verdict of the most significant slice drives the output pins. The block is purely combinational: a result follows the operands with no clock, no reset and no handshake. With the default of two slices it is an 8-bit comparator.

Top module: `cmp_chain`

## Requirements
- R1: Exactly one of `gt_o`, `eq_o`, `lt_o` is high for every pair of operand values.
- R2: When the upper nibble of `a_i` is greater than the upper nibble of `b_i`, `gt_o` is high whatever the lower nibbles hold.
- R3: When the upper nibble of `a_i` is less than the upper nibble of `b_i`, `lt_o` is high whatever the lower nibbles hold.
- R4: When the upper nibbles are equal, the outputs repeat the verdict of the lower slice (the order of the lower nibbles).
- R5: `eq_o` is high exactly when every bit of `a_i` matches the same bit of `b_i`. This is the AND of the bitwise XNORs.
- R6: The lowest slice is seeded with greater=0, equal=1, less=0, so equal operands yield `eq_o`=1, `gt_o`=0, `lt_o`=0.
- R7: Bit 0 is the least significant bit and bit 7 the most significant. Operands that differ only in bit 0 are ordered by that bit. A difference in bit 7 decides the result over any lower bits.
- R8: With `SLICES`=2 the flags equal an unsigned 8-bit comparison of `a_i` and `b_i` for all 65536 operand pairs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 4*SLICES (8) | First unsigned operand |
| b_i | input | 4*SLICES (8) | Second unsigned operand |
| gt_o | output | 1 | High when a_i > b_i |
| eq_o | output | 1 | High when a_i == b_i |
| lt_o | output | 1 | High when a_i < b_i |

## Verification
The in-line checks assume that the verdict entering each slice has exactly one flag set. The wrapper meets this by construction: it feeds the bottom slice the constant equal verdict, and every slice hands one-hot flags upward. The stimulus drives only the two operand buses, so it cannot break that assumption. It mixes seeded random pairs and directed pairs with a full sweep of all operand pairs.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
  typedef struct packed {
    logic gt;
    logic eq;
    logic lt;
  } rel_t;

  localparam rel_t REL_SEED = '{gt: 1'b0, eq: 1'b1, lt: 1'b0};
endpackage

// File: rtl/cmp_nibble_rel.sv
module cmp_nibble_rel
  import cmp_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output rel_t         rel
);
  logic [W-1:0] bit_same;
  logic [W-1:0] bit_gt;
  logic [W-1:0] bit_lt;
  logic [W:0]   above_same;

  assign above_same[W] = 1'b1;

  for (genvar i = W - 1; i >= 0; i--) begin : g_bit
    assign bit_same[i]   = ~(a[i] ^ b[i]);
    assign above_same[i] = above_same[i+1] & bit_same[i];
    assign bit_gt[i]     = a[i] & ~b[i] & above_same[i+1];
    assign bit_lt[i]     = ~a[i] & b[i] & above_same[i+1];
  end

  assign rel.eq = &bit_same;
  assign rel.gt = |bit_gt;
  assign rel.lt = |bit_lt;

  always_comb begin
    // R1
    local_onehot_chk: assert ($onehot({rel.gt, rel.eq, rel.lt}))
      else $error("local verdict not one-hot");
  end
endmodule

// File: rtl/cmp_merge.sv
module cmp_merge
  import cmp_pkg::*;
(
  input  rel_t here,
  input  rel_t below,
  output rel_t out
);
  always_comb begin
    if (here.eq) out = below;
    else         out = here;
  end
endmodule

// File: rtl/cmp_slice.sv
module cmp_slice
  import cmp_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  rel_t         casc_in,
  output rel_t         casc_out
);
  rel_t local_rel;

  cmp_nibble_rel #(.W(W)) u_rel (
    .a  (a),
    .b  (b),
    .rel(local_rel)
  );

  cmp_merge u_merge (
    .here (local_rel),
    .below(casc_in),
    .out  (casc_out)
  );

  always_comb begin
    // R2
    slice_gt_wins_chk: assert (!local_rel.gt || casc_out.gt)
      else $error("local greater lost");
    // R3
    slice_lt_wins_chk: assert (!local_rel.lt || casc_out.lt)
      else $error("local less lost");
    // R4
    slice_pass_chk: assert (!local_rel.eq || (casc_out == casc_in))
      else $error("cascade not passed through");
    // R1
    slice_onehot_chk: assert (!$onehot({casc_in.gt, casc_in.eq, casc_in.lt})
                              || $onehot({casc_out.gt, casc_out.eq, casc_out.lt}))
      else $error("slice verdict not one-hot");
  end
endmodule

// File: rtl/cmp_chain.sv
module cmp_chain
  import cmp_pkg::*;
#(
  parameter int SLICES  = 2,
  parameter int SLICE_W = 4
) (
  input  logic [SLICES*SLICE_W-1:0] a_i,
  input  logic [SLICES*SLICE_W-1:0] b_i,
  output logic                      gt_o,
  output logic                      eq_o,
  output logic                      lt_o
);
  localparam int TOTAL_W = SLICES * SLICE_W;

  rel_t link [SLICES+1];

  assign link[0] = REL_SEED;

  for (genvar s = 0; s < SLICES; s++) begin : g_slice
    cmp_slice #(.W(SLICE_W)) u_slice (
      .a       (a_i[s*SLICE_W +: SLICE_W]),
      .b       (b_i[s*SLICE_W +: SLICE_W]),
      .casc_in (link[s]),
      .casc_out(link[s+1])
    );
  end

  assign gt_o = link[SLICES].gt;
  assign eq_o = link[SLICES].eq;
  assign lt_o = link[SLICES].lt;

  always_comb begin
    // R1
    out_onehot_chk: assert ($onehot({gt_o, eq_o, lt_o}))
      else $error("output flags not one-hot");
    // R5
    out_eq_bits_chk: assert (eq_o == (a_i == b_i))
      else $error("equal flag disagrees with operands");
    // R7
    out_msb_chk: assert ((a_i[TOTAL_W-1] == b_i[TOTAL_W-1])
                         || (gt_o == a_i[TOTAL_W-1]))
      else $error("top bit did not decide");
  end
endmodule

// File: tb/cmp_chain_bench.sv
`timescale 1ns/1ps
module cmp_chain_bench;
  localparam int W = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [W-1:0] a, b;
  logic gt, eq, lt;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  cmp_chain u_cmp_chain (
    .a_i (a),
    .b_i (b),
    .gt_o(gt),
    .eq_o(eq),
    .lt_o(lt)
  );

  function automatic logic [2:0] expect_flags(logic [W-1:0] x, logic [W-1:0] y);
    return {x > y, x == y, x < y};
  endfunction

  function automatic string tag_of(logic [W-1:0] x, logic [W-1:0] y);
    if (x[7:4] > y[7:4]) return "R2";
    if (x[7:4] < y[7:4]) return "R3";
    return "R4";
  endfunction

  task automatic apply(input logic [W-1:0] x, input logic [W-1:0] y, input string tag);
    @(posedge clk);
    a = x;
    b = y;
    @(negedge clk);
    checks++;
    if ({gt, eq, lt} !== expect_flags(x, y)) begin
      errors++;
      $display("FAIL %s a=%h b=%h got gt/eq/lt=%b expected %b",
               tag, x, y, {gt, eq, lt}, expect_flags(x, y));
    end
  endtask

  task automatic check_onehot;
    checks++;
    if ($countones({gt, eq, lt}) != 1) begin
      errors++;
      $display("FAIL R1 a=%h b=%h got gt/eq/lt=%b expected one flag", a, b, {gt, eq, lt});
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed = 32'd1234;
    a = '0;
    b = '0;
    // R6: seeded equal verdict with equal operands at start
    apply(8'h00, 8'h00, "R6");
    apply(8'hA5, 8'hA5, "R6");
    // R5: equality needs every bit
    apply(8'hFF, 8'hFF, "R5");
    apply(8'hFF, 8'hFE, "R5");
    // R2/R3: upper nibble overrides the lower one
    apply(8'h50, 8'h4F, "R2");
    apply(8'h4F, 8'h50, "R3");
    // R4: equal upper nibbles, lower decides
    apply(8'h39, 8'h38, "R4");
    apply(8'h38, 8'h39, "R4");
    // R7: bit 0 lowest, bit 7 dominant
    apply(8'h01, 8'h00, "R7");
    apply(8'h00, 8'h01, "R7");
    apply(8'h80, 8'h7F, "R7");
    apply(8'h7F, 8'h80, "R7");
    check_onehot();
    // seeded random pairs
    void'($urandom(seed));
    for (int k = 0; k < 2000; k++) begin
      logic [W-1:0] x, y;
      x = W'($urandom);
      y = W'($urandom);
      apply(x, y, tag_of(x, y));
      check_onehot();
    end
    // R8: full sweep
    for (int i = 0; i < 256; i++) begin
      for (int j = 0; j < 256; j++) begin
        apply(W'(i), W'(j), "R8");
        check_onehot();
      end
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule